// File: doc/BRIEF.md
# Banked Clock Fanout with Gated Enables

This block takes one of two clock sources, picked by a select input, and fans it out to four banks of four outputs each. Every bank decides on its own whether it passes the source at full rate or at half rate. Every bank also has its own enable. A disabled bank holds its outputs driven low. An enable change reaches the outputs only at the start of a low phase of that bank's clock, so no shortened high pulse can appear.

An active-low master reset clears every half-rate divider. While it is low, every output is released to high impedance. The block is clock-path logic: a source multiplexer, one toggle flop per bank, an enable latch per bank, and output gating. It does not drive pads itself. Each output comes with a drive-enable bit, which the pad ring uses to turn its driver on or off.

Top module: `fanout_top`

## Requirements
- R1: When `clk_sel` is 1, every bank is derived from `clk_b`; when it is 0, every bank is derived from `clk_a`.
- R2: Bank b drives `q_out[4b+3:4b]`, and all four outputs of a bank always carry the same waveform.
- R3: With `div_sel[b]` = 0 and the bank enabled, the bank's period equals the source period, and the bank is high whenever the source is high.
- R4: With `div_sel[b]` = 1 and the bank enabled, the bank's period is twice the source period. Its level inverts on every rising edge of the source.
- R5: With `bank_en[b]` = 0, the bank's outputs are driven low (`q_oe` stays 1) once the bank clock has passed through a low phase.
- R6: An enable change takes effect only at the start of a low phase of the bank clock. No high pulse on an output is shorter than one high phase of that bank's clock: half a source period at full rate, one source period at half rate.
- R7: While `rst_n` is 0, all dividers are held cleared and `q_out` is all 0. After release, a half-rate bank stays low until the first source rising edge and goes high at that edge.
- R8: `q_oe` bit i is the drive enable of output i, with 1 = driven and 0 = high impedance. All bits are 0 while `rst_n` is 0 and 1 otherwise, whatever the enables and divide selects are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | First clock source |
| clk_b | input | 1 | Second clock source |
| clk_sel | input | 1 | Source select: 1 picks clk_b, 0 picks clk_a |
| rst_n | input | 1 | Master reset and output enable, active low |
| div_sel | input | 4 | Per-bank rate: 1 = half rate, 0 = full rate |
| bank_en | input | 4 | Per-bank enable, active high |
| q_out | output | 16 | Clock outputs, four per bank |
| q_oe | output | 16 | Per-output drive enable for the pad, 1 = driven |

## Verification
Several relations are checked on every falling edge of the selected source:
- a bank enabled at full rate is high;
- a bank enabled at half rate alternates between successive samples;
- a bank whose enable stayed low is low;
- during reset, every drive enable and output is 0.

The period seen for each source-select and divide combination, the absence of shortened pulses under enables toggled at random times, the first edge after reset release, and the half-cycle timing of an enable change can only be shown by the bench's timed scenarios.

// File: rtl/fanout_pkg.sv
// Shared types for the banked clock fanout.
// Assumes: one bit per bank selects the rate.
package fanout_pkg;

    // Rate choice of one bank
    typedef enum logic {
        RATE_FULL = 1'b0,
        RATE_HALF = 1'b1
    } rate_e;

endpackage

// File: rtl/clk_src_mux.sv
// Picks one of two clock sources.
// Assumes: the select is changed only when a glitch on the output is acceptable.
module clk_src_mux (
    input  logic clk_a,
    input  logic clk_b,
    input  logic sel,
    output logic clk_o
);

    // Source selection: 1 takes the second source
    always_comb begin
        clk_o = sel ? clk_b : clk_a;
    end

endmodule

// File: rtl/bank_divider.sv
// Produces one bank's clock, either the source itself or the source halved.
// The toggle flop always runs; the rate choice only picks which signal leaves.
// Assumes: rst_n is held low across at least one rising source edge to clear.
module bank_divider
    import fanout_pkg::*;
(
    input  logic  src_clk,
    input  logic  rst_n,
    input  rate_e mode,
    output logic  bank_clk
);

    logic half_q;

    // Toggle flop that halves the source, cleared by synchronous reset
    always_ff @(posedge src_clk) begin
        if (!rst_n) begin
            half_q <= 1'b0;
        end else begin
            half_q <= ~half_q;
        end
    end

    // Rate selection for the bank
    always_comb begin
        bank_clk = (mode == RATE_HALF) ? half_q : src_clk;
    end

endmodule

// File: rtl/bank_gate.sv
// Gates one bank clock with its enable, free of runt pulses.
// The enable is held in a latch that is open only while the bank clock is
// low. A change therefore lands at the start of a low phase, and a high
// phase that has begun is never cut short.
// Assumes: the enable is stable for a few source periods around each change.
module bank_gate (
    input  logic bank_clk,
    input  logic en,
    output logic gated
);

    logic en_hold;

    // Enable latch, transparent during the low phase of the bank clock
    always_latch begin
        if (!bank_clk) begin
            en_hold = en;
        end
    end

    // AND gate that produces the bank waveform
    always_comb begin
        gated = bank_clk & en_hold;
    end

endmodule

// File: rtl/fanout_top.sv
// Banked clock fanout: source select, per-bank full or half rate,
// per-bank runt-free enable, and a master reset that releases the pads.
// Assumes: the pad ring turns q_oe into high impedance.
module fanout_top #(
    parameter int NUM_BANKS     = 4,
    parameter int OUTS_PER_BANK = 4
) (
    input  logic                                 clk_a,
    input  logic                                 clk_b,
    input  logic                                 clk_sel,
    input  logic                                 rst_n,
    input  logic [NUM_BANKS-1:0]                 div_sel,
    input  logic [NUM_BANKS-1:0]                 bank_en,
    output logic [NUM_BANKS*OUTS_PER_BANK-1:0]   q_out,
    output logic [NUM_BANKS*OUTS_PER_BANK-1:0]   q_oe
);
    import fanout_pkg::*;

    localparam int NUM_OUTS = NUM_BANKS * OUTS_PER_BANK;

    logic src_clk;

    clk_src_mux u_mux (
        .clk_a (clk_a),
        .clk_b (clk_b),
        .sel   (clk_sel),
        .clk_o (src_clk)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic bank_clk;
        logic bank_wave;

        bank_divider u_div (
            .src_clk  (src_clk),
            .rst_n    (rst_n),
            .mode     (rate_e'(div_sel[b])),
            .bank_clk (bank_clk)
        );

        bank_gate u_gate (
            .bank_clk (bank_clk),
            .en       (bank_en[b]),
            .gated    (bank_wave)
        );

        for (genvar o = 0; o < OUTS_PER_BANK; o++) begin : g_out
            // Output copy of the bank waveform, forced low during reset
            assign q_out[b*OUTS_PER_BANK + o] = rst_n & bank_wave;
            // Pad drive enable, released during reset
            assign q_oe[b*OUTS_PER_BANK + o]  = rst_n;
        end
    end

    // Width guard on the derived output count
    initial begin
        if ($bits(q_out) != NUM_OUTS) $display("width mismatch on q_out");
    end

endmodule

// File: rtl/fanout_chk.sv
// Checker for the banked clock fanout.
// Samples on falling edges of the selected source.
module fanout_chk #(
    parameter int NUM_BANKS     = 4,
    parameter int OUTS_PER_BANK = 4
) (
    input logic                               src_clk,
    input logic                               rst_n,
    input logic [NUM_BANKS-1:0]               div_sel,
    input logic [NUM_BANKS-1:0]               bank_en,
    input logic [NUM_BANKS*OUTS_PER_BANK-1:0] q_out,
    input logic [NUM_BANKS*OUTS_PER_BANK-1:0] q_oe
);

    // Reset state of the pads, sampled on each falling source edge
    always @(negedge src_clk) begin
        if (!rst_n) begin
            // R7 R8
            reset_release_chk: assert (q_oe == '0 && q_out == '0)
                else $error("outputs not released during reset");
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int REP = b * OUTS_PER_BANK;

        // R3
        full_rate_chk: assert property (@(negedge src_clk) disable iff (!rst_n)
            ($past(rst_n) && !div_sel[b] && !$past(div_sel[b]) &&
             bank_en[b] && $past(bank_en[b]) && $past(bank_en[b], 2))
            |-> q_out[REP]);

        // R4
        half_rate_chk: assert property (@(negedge src_clk) disable iff (!rst_n)
            ($past(rst_n) && div_sel[b] && $past(div_sel[b]) && $past(div_sel[b], 2) &&
             bank_en[b] && $past(bank_en[b]) && $past(bank_en[b], 2) && $past(bank_en[b], 3))
            |-> (q_out[REP] != $past(q_out[REP])));

        // R5
        bank_off_chk: assert property (@(negedge src_clk) disable iff (!rst_n)
            (!bank_en[b] && !$past(bank_en[b]) && !$past(bank_en[b], 2))
            |-> (!q_out[REP] && q_oe[REP]));
    end

endmodule

bind fanout_top fanout_chk #(
    .NUM_BANKS     (NUM_BANKS),
    .OUTS_PER_BANK (OUTS_PER_BANK)
) u_chk (
    .src_clk (src_clk),
    .rst_n   (rst_n),
    .div_sel (div_sel),
    .bank_en (bank_en),
    .q_out   (q_out),
    .q_oe    (q_oe)
);

// File: tb/fanout_top_test.sv
`timescale 1ns/1ps
module fanout_top_test;

    localparam int CLK_PERIOD   = 10;
    localparam int CLK_B_PERIOD = 14;
    localparam int NB  = 4;
    localparam int OPB = 4;
    localparam int NO  = NB * OPB;
    localparam int WATCHDOG = CLK_PERIOD * 200000;

    // Stimulus rows: [8] select, [7:4] divide selects, [3:0] enables
    localparam logic [8:0] VEC_TABLE [0:7] = '{
        9'b0_0000_1111,
        9'b0_1111_1111,
        9'b0_0101_1111,
        9'b1_0011_1111,
        9'b1_1111_1010,
        9'b0_1100_0110,
        9'b1_0000_0001,
        9'b0_1010_0000
    };

    logic          clk_a = 1'b0;
    logic          clk_b = 1'b0;
    logic          clk_sel;
    logic          rst_n;
    logic [NB-1:0] div_sel;
    logic [NB-1:0] bank_en;
    logic [NO-1:0] q_out;
    logic [NO-1:0] q_oe;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2)   clk_a = ~clk_a;
    always #(CLK_B_PERIOD / 2) clk_b = ~clk_b;

    fanout_top uut (
        .clk_a   (clk_a),
        .clk_b   (clk_b),
        .clk_sel (clk_sel),
        .rst_n   (rst_n),
        .div_sel (div_sel),
        .bank_en (bank_en),
        .q_out   (q_out),
        .q_oe    (q_oe)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Polls one bank for 120 ns, off the clock edges
    task automatic measure(input int b, output int period, output bit same,
                           output bit low_all, output bit oe_all);
        int last = -1;
        int prev = -1;
        bit pv   = q_out[b*OPB];
        period  = 0;
        same    = 1'b1;
        low_all = 1'b1;
        oe_all  = 1'b1;
        for (int t = 0; t < 120; t++) begin
            bit cur;
            #1;
            cur = q_out[b*OPB];
            for (int o = 0; o < OPB; o++) begin
                if (q_out[b*OPB+o] != cur) same = 1'b0;
                if (!q_oe[b*OPB+o]) oe_all = 1'b0;
            end
            if (cur) low_all = 1'b0;
            if (cur && !pv) begin
                prev = last;
                last = t;
            end
            pv = cur;
        end
        if (prev >= 0) period = last - prev;
    endtask

    initial begin
        #WATCHDOG;
        errors++;
        checks++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        bit done;
        clk_sel = 1'b0;
        div_sel = '1;
        bank_en = '1;
        rst_n   = 1'b0;
        #2.5;
        // R8 R7: reset state
        check(q_oe == '0, "R8", "q_oe in reset", int'(q_oe), 0);
        check(q_out == '0, "R7", "q_out in reset", int'(q_out), 0);
        #30;
        rst_n = 1'b1;
        #20;
        check(q_oe == '1, "R8", "q_oe after release", int'(q_oe), 16'hFFFF);

        // Table walk: R1 R2 R3 R4 R5
        for (int v = 0; v < 8; v++) begin
            clk_sel = VEC_TABLE[v][8];
            div_sel = VEC_TABLE[v][7:4];
            bank_en = VEC_TABLE[v][3:0];
            #60;
            for (int b = 0; b < NB; b++) begin
                int per;
                int exp_per;
                bit same;
                bit low_all;
                bit oe_all;
                measure(b, per, same, low_all, oe_all);
                exp_per = (div_sel[b] ? 2 : 1) * (clk_sel ? CLK_B_PERIOD : CLK_PERIOD);
                check(same, "R2", $sformatf("vec %0d bank %0d outputs equal", v, b), int'(same), 1);
                check(oe_all, "R8", $sformatf("vec %0d bank %0d driven", v, b), int'(oe_all), 1);
                if (bank_en[b]) begin
                    check(per == exp_per, div_sel[b] ? "R4 R1" : "R3 R1",
                          $sformatf("vec %0d bank %0d period", v, b), per, exp_per);
                end else begin
                    check(low_all, "R5", $sformatf("vec %0d bank %0d held low", v, b),
                          int'(!low_all), 0);
                end
            end
        end

        // R6: enable dropped and raised in the middle of a high phase, full rate
        clk_sel = 1'b0;
        div_sel = '0;
        bank_en = '1;
        #60;
        @(posedge clk_a);
        #1.5;
        bank_en[0] = 1'b0;
        #1;
        check(q_out[0] == 1'b1, "R6", "high phase kept after disable", int'(q_out[0]), 1);
        @(negedge clk_a);
        #0.5;
        check(q_out[0] == 1'b0, "R6", "low after disable", int'(q_out[0]), 0);
        @(posedge clk_a);
        #0.5;
        check(q_out[0] == 1'b0, "R5", "disabled bank stays low", int'(q_out[0]), 0);
        #1;
        bank_en[0] = 1'b1;
        #1;
        check(q_out[0] == 1'b0, "R6", "no partial pulse on enable", int'(q_out[0]), 0);
        @(posedge clk_a);
        #0.5;
        check(q_out[0] == 1'b1, "R6", "enabled at next high phase", int'(q_out[0]), 1);

        // R6: enables toggled at random times, pulse widths measured
        div_sel = 4'b1100;
        #60;
        done = 1'b0;
        fork
            begin
                repeat (40) begin
                    #($urandom_range(25, 90));
                    bank_en[$urandom_range(0, NB-1)] ^= 1'b1;
                end
                done = 1'b1;
            end
            begin
                bit pv [NB];
                int rise_t [NB];
                int runts [NB];
                int pulses [NB];
                int t = 0;
                for (int b = 0; b < NB; b++) begin
                    pv[b] = q_out[b*OPB];
                    rise_t[b] = -1;
                    runts[b] = 0;
                    pulses[b] = 0;
                end
                while (!done) begin
                    #1;
                    t++;
                    for (int b = 0; b < NB; b++) begin
                        bit cur;
                        int exp_w;
                        cur = q_out[b*OPB];
                        exp_w = div_sel[b] ? CLK_PERIOD : CLK_PERIOD / 2;
                        if (cur && !pv[b]) rise_t[b] = t;
                        if (!cur && pv[b] && rise_t[b] >= 0) begin
                            pulses[b]++;
                            if (t - rise_t[b] < exp_w) begin
                                runts[b]++;
                                $display("FAIL R6 bank %0d pulse width: actual %0d expected %0d",
                                         b, t - rise_t[b], exp_w);
                            end
                        end
                        pv[b] = cur;
                    end
                end
                for (int b = 0; b < NB; b++) begin
                    checks++;
                    if (runts[b] != 0) errors++;
                    check(pulses[b] > 0, "R6", $sformatf("bank %0d pulses seen", b), pulses[b], 1);
                end
            end
        join

        // R7: first half-rate edge after reset release
        bank_en = '1;
        div_sel = '1;
        rst_n   = 1'b0;
        #40;
        check(q_oe == '0, "R8", "q_oe during second reset", int'(q_oe), 0);
        check(q_out == '0, "R7", "q_out with banks enabled in reset", int'(q_out), 0);
        @(negedge clk_a);
        #1.5;
        rst_n = 1'b1;
        #1;
        check(q_out[0] == 1'b0, "R7", "half-rate bank low after release", int'(q_out[0]), 0);
        @(posedge clk_a);
        #0.5;
        check(q_out[0] == 1'b1, "R7", "first edge after release", int'(q_out[0]), 1);
        @(posedge clk_a);
        #0.5;
        check(q_out[0] == 1'b0, "R4", "second edge after release", int'(q_out[0]), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule